// File: doc/BRIEF.md
# LCD Pixel Format and Palette Expander

This block sits between a frame-buffer fetch path and a display panel interface. It accepts 32-bit words of packed pixel data and emits one 18-bit colour word per pixel. The output word is laid out as red in bits 17:12, green in bits 11:6 and blue in bits 5:0. Two configuration pins pick the panel class (passive colour or TFT) and a pixel-depth code. Indexed depths fetch their colour from a 256-entry palette RAM, which software fills through a dedicated write port. Direct-colour depths take their channel fields straight from the pixel bits. Any field narrower than 6 bits is widened by copying its top bits into the vacant low bits.

Both streams use valid/ready. A transfer happens on a rising clock edge where valid and ready are both high. A source that raises valid keeps its data steady until the transfer takes place. While `px_ready` is low, the block holds its output word unchanged. The stall then propagates to the input: `fb_ready` drops as soon as the internal pixel slots are full. Every pixel reaches the output exactly once, in order. The configuration pins are expected to change only while the block is empty.

Top module: `lcd_pixel_expander`

## Requirements
- R1: After reset, `px_valid` is 0 and `fb_ready` is 1.
- R2: Depth code `cfg_bpp` decodes as 0 = 4 bpp indexed and 1 = 8 bpp indexed on both panel classes. On TFT (`cfg_tft`=1), 2 = 12 bpp, 3 = 16 bpp, and any code of 4 or more = 18 bpp. On passive colour (`cfg_tft`=0), every code of 2 or more = 12 bpp.
- R3: Pixels are taken from each input word starting at bit 0, with 8, 4, 2, 2 and 1 pixels per word for 4, 8, 12, 16 and 18 bpp. At 12 bpp the pixels are bits 11:0 and 23:12, and bits 31:24 are ignored. At 18 bpp the pixel is bits 17:0.
- R4: On a passive panel, an indexed pixel reads the palette entry at that index and uses entry bits 11:0 as RGB444 (red 11:8, green 7:4, blue 3:0). Each 4-bit channel abcd is output as abcdab.
- R5: On a TFT panel, an indexed pixel outputs all 18 bits of the addressed palette entry unchanged. A 4 bpp index reaches entries 0 to 15 only.
- R6: At 12 bpp the pixel bits are read as RGB444 (red 11:8, green 7:4, blue 3:0), and each channel is widened as in R4.
- R7: At 16 bpp, red is pixel bits 15:11, green 10:5 and blue 4:0. Each 5-bit channel v is output as {v, v[4]}.
- R8: At 18 bpp the pixel bits are output unchanged.
- R9: A palette write (`pal_we`=1) stores `pal_wdata` at `pal_addr`. Pixels that read the palette in any later cycle see the new value.
- R10: When the block is empty and a word is accepted at clock edge t, its first pixel is presented at edge t+2, in indexed and direct modes alike.
- R11: While `px_valid`=1 and `px_ready`=0, `px_valid` and `px_data` stay unchanged, and `fb_ready` goes low once the internal pixel slots are full.
- R12: Each accepted word produces exactly its R3 pixel count on the output, in order, with no pixel lost or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tft | input | 1 | Panel class: 1 = TFT, 0 = passive colour |
| cfg_bpp | input | 3 | Pixel-depth code (R2) |
| pal_we | input | 1 | Palette write strobe |
| pal_addr | input | 8 | Palette write index |
| pal_wdata | input | 18 | Palette write data |
| fb_valid | input | 1 | Input word valid |
| fb_ready | output | 1 | Input word accepted when high with fb_valid |
| fb_data | input | 32 | Packed frame-buffer word |
| px_valid | output | 1 | Output pixel valid |
| px_ready | input | 1 | Downstream ready for a pixel |
| px_data | output | 18 | Pixel colour, red 17:12, green 11:6, blue 5:0 |

## Verification
The hardest situation to reach from the ports is a full pipeline held under back-pressure while a partly unpacked word is still waiting. In that state the next word must be refused, and the word already inside must still drain without loss. The stimulus reaches it by holding `px_ready` low across the acceptance of an 8 bpp word. It then checks that the first pixel stays frozen and that the input is refused. Finally it releases the stall and checks that the four pixels come out back to back, followed by an empty output. The table-driven runs add irregular `px_ready` patterns on every depth and panel class, so stalls also land in the middle of words.

// File: rtl/lpx_pkg.sv
package lpx_pkg;

  localparam int PIX_W = 18;

  typedef enum logic [2:0] {
    PM_IDX4  = 3'd0,
    PM_IDX8  = 3'd1,
    PM_RGB12 = 3'd2,
    PM_RGB16 = 3'd3,
    PM_RGB18 = 3'd4
  } pix_mode_e;

  // Panel class and depth code to an unpacking mode
  function automatic pix_mode_e decode_mode(input logic tft, input logic [2:0] code);
    pix_mode_e m;
    if (code == 3'd0)      m = PM_IDX4;
    else if (code == 3'd1) m = PM_IDX8;
    else if (!tft)         m = PM_RGB12;
    else if (code == 3'd2) m = PM_RGB12;
    else if (code == 3'd3) m = PM_RGB16;
    else                   m = PM_RGB18;
    return m;
  endfunction

  function automatic logic [3:0] pix_per_word(input pix_mode_e m);
    case (m)
      PM_IDX4:  return 4'd8;
      PM_IDX8:  return 4'd4;
      PM_RGB12: return 4'd2;
      PM_RGB16: return 4'd2;
      default:  return 4'd1;
    endcase
  endfunction

  function automatic logic [4:0] pix_bits(input pix_mode_e m);
    case (m)
      PM_IDX4:  return 5'd4;
      PM_IDX8:  return 5'd8;
      PM_RGB12: return 5'd12;
      PM_RGB16: return 5'd16;
      default:  return 5'd18;
    endcase
  endfunction

  function automatic logic [5:0] widen4(input logic [3:0] v);
    return {v, v[3:2]};
  endfunction

  function automatic logic [5:0] widen5(input logic [4:0] v);
    return {v, v[4]};
  endfunction

  function automatic logic [PIX_W-1:0] rgb444_to_666(input logic [11:0] c);
    return {widen4(c[11:8]), widen4(c[7:4]), widen4(c[3:0])};
  endfunction

endpackage

// File: rtl/lpx_unpack.sv
module lpx_unpack
  import lpx_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fb_valid,
  output logic              fb_ready,
  input  logic [WORD_W-1:0] fb_data,
  input  pix_mode_e         mode,
  input  logic              take,
  output logic              pix_valid,
  output logic [PIX_W-1:0]  pix_raw
);

  logic [WORD_W-1:0] word_q;
  logic [2:0]        idx_q;
  logic              hold_q;
  logic [3:0]        ppw;
  logic [4:0]        bits;
  logic              last;
  logic [7:0]        shamt;
  logic [PIX_W-1:0]  shifted;
  logic [PIX_W-1:0]  mask;

  assign ppw      = pix_per_word(mode);
  assign bits     = pix_bits(mode);
  assign last     = ({1'b0, idx_q} == (ppw - 4'd1));
  assign shamt    = {5'd0, idx_q} * {3'd0, bits};
  assign shifted  = PIX_W'(word_q >> shamt);
  assign mask     = PIX_W'((19'd1 << bits) - 19'd1);
  assign pix_raw  = shifted & mask;
  assign pix_valid = hold_q;
  assign fb_ready  = !hold_q || (take && last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= '0;
      hold_q <= 1'b0;
    end else if (fb_valid && fb_ready) begin
      word_q <= fb_data;
      idx_q  <= '0;
      hold_q <= 1'b1;
    end else if (take) begin
      if (last) hold_q <= 1'b0;
      else      idx_q  <= idx_q + 3'd1;
    end
  end

endmodule

// File: rtl/lpx_palette_ram.sv
module lpx_palette_ram #(
  parameter int DEPTH  = 256,
  parameter int DATA_W = 18,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/lpx_widen.sv
module lpx_widen
  import lpx_pkg::*;
(
  input  pix_mode_e        mode,
  input  logic [PIX_W-1:0] raw,
  output logic [PIX_W-1:0] rgb
);

  always_comb begin
    case (mode)
      PM_RGB12: rgb = rgb444_to_666(raw[11:0]);
      PM_RGB16: rgb = {widen5(raw[15:11]), raw[10:5], widen5(raw[4:0])};
      default:  rgb = raw;
    endcase
  end

endmodule

// File: rtl/lcd_pixel_expander.sv
module lcd_pixel_expander
  import lpx_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int PAL_DEPTH = 256,
  localparam int PAL_AW   = $clog2(PAL_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_tft,
  input  logic [2:0]        cfg_bpp,
  input  logic              pal_we,
  input  logic [PAL_AW-1:0] pal_addr,
  input  logic [PIX_W-1:0]  pal_wdata,
  input  logic              fb_valid,
  output logic              fb_ready,
  input  logic [WORD_W-1:0] fb_data,
  output logic              px_valid,
  input  logic              px_ready,
  output logic [PIX_W-1:0]  px_data
);

  pix_mode_e        mode;
  logic             a_valid;
  logic [PIX_W-1:0] a_raw;
  logic             take;
  logic             is_idx;
  logic [PIX_W-1:0] direct_rgb;
  logic [PIX_W-1:0] pal_rd;

  logic             b_valid;
  logic             b_idx;
  logic             b_tft;
  logic [PIX_W-1:0] b_direct;

  assign mode   = decode_mode(cfg_tft, cfg_bpp);
  assign is_idx = (mode == PM_IDX4) || (mode == PM_IDX8);
  assign take   = a_valid && (!b_valid || px_ready);

  lpx_unpack #(.WORD_W(WORD_W)) u_unpack (
    .clk       (clk),
    .rst_n     (rst_n),
    .fb_valid  (fb_valid),
    .fb_ready  (fb_ready),
    .fb_data   (fb_data),
    .mode      (mode),
    .take      (take),
    .pix_valid (a_valid),
    .pix_raw   (a_raw)
  );

  lpx_widen u_widen (
    .mode (mode),
    .raw  (a_raw),
    .rgb  (direct_rgb)
  );

  lpx_palette_ram #(.DEPTH(PAL_DEPTH), .DATA_W(PIX_W)) u_pal (
    .clk   (clk),
    .we    (pal_we),
    .waddr (pal_addr),
    .wdata (pal_wdata),
    .re    (take && is_idx),
    .raddr (a_raw[PAL_AW-1:0]),
    .rdata (pal_rd)
  );

  // Output stage: both paths spend exactly one register here
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      b_valid  <= 1'b0;
      b_idx    <= 1'b0;
      b_tft    <= 1'b0;
      b_direct <= '0;
    end else if (take) begin
      b_valid  <= 1'b1;
      b_idx    <= is_idx;
      b_tft    <= cfg_tft;
      b_direct <= direct_rgb;
    end else if (px_ready) begin
      b_valid  <= 1'b0;
    end
  end

  assign px_valid = b_valid;
  assign px_data  = !b_idx ? b_direct :
                    (b_tft ? pal_rd : rgb444_to_666(pal_rd[11:0]));

endmodule

// File: rtl/lpx_checker.sv
module lpx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        fb_valid,
  input logic        fb_ready,
  input logic        px_valid,
  input logic        px_ready,
  input logic [17:0] px_data
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!px_valid && fb_ready));

  // R11
  stall_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && !px_ready) |=> px_valid);

  // R11
  stall_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && !px_ready) |=> $stable(px_data));

  // R10
  fill_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_valid && fb_ready && !px_valid) |=> ##1 px_valid);

endmodule

bind lcd_pixel_expander lpx_checker u_lpx_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fb_valid (fb_valid),
  .fb_ready (fb_ready),
  .px_valid (px_valid),
  .px_ready (px_ready),
  .px_data  (px_data)
);

// File: tb/lcd_pixel_expander_bench.sv
module lcd_pixel_expander_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_tft = 1'b0;
  logic [2:0]  cfg_bpp = 3'd0;
  logic        pal_we = 1'b0;
  logic [7:0]  pal_addr = 8'd0;
  logic [17:0] pal_wdata = 18'd0;
  logic        fb_valid = 1'b0;
  logic        fb_ready;
  logic [31:0] fb_data = 32'd0;
  logic        px_valid;
  logic        px_ready = 1'b0;
  logic [17:0] px_data;

  int compared = 0;
  int mismatched = 0;

  logic [17:0] pal_sh [256];
  logic [31:0] wq [$];
  logic [17:0] exp_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  lcd_pixel_expander u_lcd_pixel_expander (
    .clk(clk), .rst_n(rst_n), .cfg_tft(cfg_tft), .cfg_bpp(cfg_bpp),
    .pal_we(pal_we), .pal_addr(pal_addr), .pal_wdata(pal_wdata),
    .fb_valid(fb_valid), .fb_ready(fb_ready), .fb_data(fb_data),
    .px_valid(px_valid), .px_ready(px_ready), .px_data(px_data)
  );

  // {tft, depth code, word}
  localparam int NV = 12;
  localparam logic [35:0] VEC [NV] = '{
    {1'b0, 3'd0, 32'h7654_3210},
    {1'b0, 3'd1, 32'hFF80_1203},
    {1'b0, 3'd2, 32'hAB0A_5F3C},
    {1'b0, 3'd5, 32'h1234_5678},
    {1'b0, 3'd3, 32'hF0F0_0F0F},
    {1'b1, 3'd0, 32'hFEDC_BA98},
    {1'b1, 3'd1, 32'h00FF_7F80},
    {1'b1, 3'd2, 32'h5A96_C3E1},
    {1'b1, 3'd3, 32'h07E0_001F},
    {1'b1, 3'd4, 32'hFFFC_0001},
    {1'b1, 3'd7, 32'h0002_ABCD},
    {1'b1, 3'd6, 32'h0001_5555}
  };

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int width_of(input logic tft, input logic [2:0] code);
    if (code == 3'd0) return 4;
    if (code == 3'd1) return 8;
    if (!tft || code == 3'd2) return 12;
    if (code == 3'd3) return 16;
    return 18;
  endfunction

  function automatic int count_of(input int w);
    if (w == 4) return 8;
    if (w == 8) return 4;
    if (w == 18) return 1;
    return 2;
  endfunction

  function automatic logic [17:0] w444(input logic [11:0] c);
    return {c[11:8], c[11:10], c[7:4], c[7:6], c[3:0], c[3:2]};
  endfunction

  // Expected colour from R3..R8
  function automatic logic [17:0] ref_pix(input logic tft, input logic [2:0] code,
                                          input logic [31:0] word, input int idx);
    int w;
    logic [63:0] raw;
    w = width_of(tft, code);
    raw = ({32'd0, word} >> (idx * w)) & ((64'd1 << w) - 64'd1);
    if (w <= 8) return tft ? pal_sh[raw[7:0]] : w444(pal_sh[raw[7:0]][11:0]);
    if (w == 12) return w444(raw[11:0]);
    if (w == 16) return {raw[15:11], raw[15], raw[10:5], raw[4:0], raw[4]};
    return raw[17:0];
  endfunction

  function automatic string tag_of(input logic tft, input logic [2:0] code);
    int w;
    w = width_of(tft, code);
    if (w <= 8) return tft ? "R5 tft-indexed" : "R4 passive-indexed";
    if (w == 12) return "R6 rgb12";
    if (w == 16) return "R7 rgb16";
    return "R8 rgb18";
  endfunction

  task automatic pal_write(input int a, input logic [17:0] d);
    @(negedge clk);
    pal_we = 1'b1; pal_addr = 8'(a); pal_wdata = d;
    pal_sh[a] = d;
    @(negedge clk);
    pal_we = 1'b0;
  endtask

  // Push wq words, collect exp_q pixels under a px_ready duty of pct percent (R12)
  task automatic run_stream(input int pct);
    int n;
    n = exp_q.size();
    fork
      begin
        while (wq.size() > 0) begin
          @(negedge clk);
          fb_valid = 1'b1;
          fb_data  = wq.pop_front();
          #1;
          while (!fb_ready) begin
            @(negedge clk);
            #1;
          end
        end
        @(negedge clk);
        fb_valid = 1'b0;
      end
      begin
        for (int got = 0; got < n; ) begin
          @(negedge clk);
          px_ready = ($urandom_range(99) < pct);
          #1;
          if (px_valid && px_ready) begin
            check(tag_q.pop_front(), px_data, exp_q.pop_front());
            got++;
          end
        end
      end
    join
    @(negedge clk);
    #1;
    check("R12 no extra pixel", {17'd0, px_valid}, 18'd0);
  endtask

  task automatic queue_word(input logic tft, input logic [2:0] code, input logic [31:0] w);
    wq.push_back(w);
    for (int i = 0; i < count_of(width_of(tft, code)); i++) begin
      exp_q.push_back(ref_pix(tft, code, w, i));
      tag_q.push_back(tag_of(tft, code));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1
    check("R1 px_valid after reset", {17'd0, px_valid}, 18'd0);
    check("R1 fb_ready after reset", {17'd0, fb_ready}, 18'd1);

    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      pal_we = 1'b1; pal_addr = 8'(k);
      pal_wdata = 18'((k * 18'h1357 + 18'h00A5) & 18'h3FFFF);
      pal_sh[k] = pal_wdata;
    end
    @(negedge clk);
    pal_we = 1'b0;

    // Table walk: R2, R3 decode and unpack order across both panel classes
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      cfg_tft = VEC[v][35];
      cfg_bpp = VEC[v][34:32];
      queue_word(cfg_tft, cfg_bpp, VEC[v][31:0]);
      queue_word(cfg_tft, cfg_bpp, ~VEC[v][31:0]);
      run_stream((v % 2 == 0) ? 100 : 55);
    end

    // R6 hand-computed widening; R3 upper bits ignored at 12 bpp
    @(negedge clk); cfg_tft = 1'b0; cfg_bpp = 3'd2;
    wq.push_back(32'hFF00_0A5F);
    exp_q.push_back(18'h2A57F); tag_q.push_back("R6 rgb12 anchor");
    exp_q.push_back(18'h00000); tag_q.push_back("R3 rgb12 top byte ignored");
    run_stream(100);

    // R7 hand-computed 5-bit widening
    @(negedge clk); cfg_tft = 1'b1; cfg_bpp = 3'd3;
    wq.push_back(32'h8000_F81F);
    exp_q.push_back(18'h3F03F); tag_q.push_back("R7 rgb16 anchor0");
    exp_q.push_back(18'h21000); tag_q.push_back("R7 rgb16 anchor1");
    run_stream(70);

    // R9 palette rewrite seen by later pixels
    pal_write(7, 18'h2BEEF);
    @(negedge clk); cfg_tft = 1'b1; cfg_bpp = 3'd1;
    wq.push_back(32'h0707_0707);
    for (int i = 0; i < 4; i++) begin
      exp_q.push_back(18'h2BEEF); tag_q.push_back("R9 palette rewrite");
    end
    run_stream(100);

    // R11 stall: hold px_ready low across an 8 bpp TFT word
    @(negedge clk);
    px_ready = 1'b0;
    fb_valid = 1'b1; fb_data = 32'h0403_0201;
    #1;
    check("R11 accept into empty block", {17'd0, fb_ready}, 18'd1);
    @(negedge clk);
    fb_valid = 1'b0;
    repeat (4) @(negedge clk);
    #1;
    check("R11 valid held", {17'd0, px_valid}, 18'd1);
    check("R11 first pixel held", px_data, pal_sh[1]);
    check("R11 input refused when full", {17'd0, fb_ready}, 18'd0);
    repeat (3) @(negedge clk);
    #1;
    check("R11 pixel still stable", px_data, pal_sh[1]);
    @(negedge clk);
    px_ready = 1'b1;
    #1;
    check("R12 drain pixel 0", px_data, pal_sh[1]);
    for (int k = 2; k <= 4; k++) begin
      @(negedge clk);
      #1;
      check("R12 drain back to back", px_data, pal_sh[k]);
    end
    @(negedge clk);
    #1;
    check("R12 empty after drain", {17'd0, px_valid}, 18'd0);

    // R10 fill latency, R8 passthrough at 18 bpp
    @(negedge clk);
    cfg_tft = 1'b1; cfg_bpp = 3'd4;
    @(negedge clk);
    fb_valid = 1'b1; fb_data = 32'hFFF3_1234;
    #1;
    check("R10 accept", {17'd0, fb_ready}, 18'd1);
    @(negedge clk);
    fb_valid = 1'b0;
    #1;
    check("R10 not yet valid one edge after accept", {17'd0, px_valid}, 18'd0);
    @(negedge clk);
    #1;
    check("R10 valid two edges after accept", {17'd0, px_valid}, 18'd1);
    check("R8 rgb18 passthrough", px_data, 18'h31234);
    @(negedge clk);
    #1;
    check("R12 single pixel per 18 bpp word", {17'd0, px_valid}, 18'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule